// File: doc/BRIEF.md
# Blank-Page-Aware ECC Status Checker

This block sits beside the error-correction decoder on the read path of a flash page. It watches the bytes of the page as they stream past, marked either as main-area bytes or as spare-area bytes. For each of two regions it keeps a running record of whether any byte differed from the erased value 0xFF. The two regions are the whole main area and a fixed window of tag bytes inside the spare area.

An erased page fails decoding, because its parity bytes are 0xFF as well, but it holds no real data. When the page ends, the block therefore combines the decoder's per-region uncorrectable flags with these blank records. It suppresses any failure in a region that read back fully erased.

The 2-bit result code is written one cycle after the end-of-page pulse, and a valid strobe marks that cycle. The code then holds until the next page ends. The records clear at each page end, so pages can follow back to back.

Top module: `ecc_blank_status`

## Requirements
- R1: While reset is asserted and after it is released, `err_code` is 2'b00 and `res_vld` is 0 until the first end-of-page pulse.
- R2: A cycle with `page_end` high is followed, one clock later, by `res_vld` high for exactly one cycle, and `err_code` takes its new value in that same cycle. `err_code` keeps its value at all other times.
- R3: If `ecc_any_err` is low when `page_end` is high, the code is 2'b00 whatever the per-region fail flags and the bytes were.
- R4: Bit 1 of the code (main-area error) is set only when `ecc_any_err` and `main_fail` are both high at `page_end` and at least one main-area byte of the page was not 0xFF.
- R5: Bit 0 of the code (tag error) is set only when `ecc_any_err` and `tag_fail` are both high at `page_end` and at least one tag byte was not 0xFF. The tag bytes are spare-area bytes with index SKIP_BYTES (4) through SKIP_BYTES+TAG_BYTES-1 (23), counting from 0 within the page.
- R6: Spare bytes with index below 4 (the skipped bytes) or index 24 and above (parity bytes) have no effect on the tag check.
- R7: A page that carries no main-area bytes (a spare-only read) never sets bit 1, even when `main_fail` is high.
- R8: The blank records restart at every page end. A non-0xFF byte in one page does not affect the result of the next page.
- R9: A byte presented with `byte_vld` high in the same cycle as `page_end` belongs to the page that is ending.
- R10: Both code bits may be set together, giving 2'b11 when both regions fail and both hold non-erased data.
- R11: `byte_val` and `byte_area` are ignored in cycles where `byte_vld` is low. Such a byte neither marks a region as non-blank nor advances the spare index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | A page byte is present this cycle |
| byte_area | input | 1 | Region of the byte: 0 main area, 1 spare area |
| byte_val | input | BYTE_W | Byte value |
| ecc_any_err | input | 1 | Decoder reported some error for the page, sampled at `page_end` |
| main_fail | input | 1 | Decoder could not correct the main area, sampled at `page_end` |
| tag_fail | input | 1 | Decoder could not correct the tag region, sampled at `page_end` |
| page_end | input | 1 | One-cycle pulse closing the page |
| err_code | output | 2 | Bit 1 main-area error, bit 0 tag error, 00 clean or corrected |
| res_vld | output | 1 | One-cycle strobe when `err_code` is updated |

## Verification
Random pages mix main-area lengths from zero upward, spare lengths that stop short of the tag window, reach into it, or pass beyond it, and sparse non-0xFF bytes. With random decoder flags, this separates masking by erased regions from true failures. Directed pages then isolate single effects. A lone bad byte at spare index 3, 4, 23 or 24 shows exactly where the tag window starts and ends. A spare-only page with a main-area fail flag separates the missing-data case from a blank one. A dirty page followed by a clean one proves the records restart. A byte that arrives together with the end pulse, and garbage on the byte lines while the strobe is low, show which cycles count toward a page.

// File: rtl/ecc_blank_pkg.sv
package ecc_blank_pkg;
  typedef enum logic {
    AREA_MAIN  = 1'b0,
    AREA_SPARE = 1'b1
  } area_e;

  localparam int unsigned CODE_TAG_BIT  = 0;
  localparam int unsigned CODE_MAIN_BIT = 1;

  typedef logic [1:0] ecc_code_t;
endpackage

// File: rtl/blank_tracker.sv
module blank_tracker #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              byte_en,
  input  logic [BYTE_W-1:0] byte_val,
  output logic              dirty_now
);
  localparam logic [BYTE_W-1:0] ERASED = {BYTE_W{1'b1}};

  logic dirty_q;
  logic dirty_d;

  // current byte is folded in so a byte arriving with clr still counts
  always_comb begin
    dirty_now = dirty_q | (byte_en & (byte_val != ERASED));
    dirty_d   = clr ? 1'b0 : dirty_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dirty_q <= 1'b0;
    else        dirty_q <= dirty_d;
  end

  // R8
  sticky_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_q && !clr) |=> dirty_q);
  // R8
  clear_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !dirty_q);
endmodule

// File: rtl/spare_window.sv
module spare_window #(
  parameter int unsigned SKIP_BYTES = 4,
  parameter int unsigned TAG_BYTES  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic byte_en,
  output logic in_win
);
  localparam int unsigned LIMIT = SKIP_BYTES + TAG_BYTES;
  localparam int unsigned CW    = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] SKIP_C  = CW'(SKIP_BYTES);
  localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    in_win = byte_en && (cnt_q >= SKIP_C) && (cnt_q < LIMIT_C);
    cnt_en = clr | (byte_en & (cnt_q < LIMIT_C));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R6
  win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT_C);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_en && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/ecc_blank_status.sv
module ecc_blank_status
  import ecc_blank_pkg::*;
#(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned SKIP_BYTES = 4,
  parameter int unsigned TAG_BYTES  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic              byte_area,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              ecc_any_err,
  input  logic              main_fail,
  input  logic              tag_fail,
  input  logic              page_end,
  output logic [1:0]        err_code,
  output logic              res_vld
);
  logic      main_en, spare_en, tag_en;
  logic      main_dirty, tag_dirty;
  ecc_code_t code_d, code_q;
  logic      vld_q;

  always_comb begin
    main_en  = byte_vld & (area_e'(byte_area) == AREA_MAIN);
    spare_en = byte_vld & (area_e'(byte_area) == AREA_SPARE);
  end

  blank_tracker #(.BYTE_W(BYTE_W)) u_main_trk (
    .clk(clk), .rst_n(rst_n), .clr(page_end),
    .byte_en(main_en), .byte_val(byte_val), .dirty_now(main_dirty)
  );

  spare_window #(.SKIP_BYTES(SKIP_BYTES), .TAG_BYTES(TAG_BYTES)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(page_end),
    .byte_en(spare_en), .in_win(tag_en)
  );

  blank_tracker #(.BYTE_W(BYTE_W)) u_tag_trk (
    .clk(clk), .rst_n(rst_n), .clr(page_end),
    .byte_en(tag_en), .byte_val(byte_val), .dirty_now(tag_dirty)
  );

  always_comb begin
    code_d = '0;
    if (ecc_any_err) begin
      code_d[CODE_MAIN_BIT] = main_fail & main_dirty;
      code_d[CODE_TAG_BIT]  = tag_fail & tag_dirty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= page_end;
      if (page_end) code_q <= code_d;
    end
  end

  assign err_code = code_q;
  assign res_vld  = vld_q;

  // R2
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_end |=> res_vld);
  // R2
  res_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(page_end));
  // R2
  hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !page_end |=> $stable(err_code));
  // R3
  no_err_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_end && !ecc_any_err) |=> (err_code == 2'b00));
  // R4
  main_bit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && err_code[CODE_MAIN_BIT]) |-> $past(main_fail && ecc_any_err));
  // R5
  tag_bit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && err_code[CODE_TAG_BIT]) |-> $past(tag_fail && ecc_any_err));
endmodule

// File: tb/ecc_blank_status_tb_top.sv
module ecc_blank_status_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_vld = 1'b0;
  logic       byte_area = 1'b0;
  logic [7:0] byte_val = 8'h00;
  logic       ecc_any_err = 1'b0;
  logic       main_fail = 1'b0;
  logic       tag_fail = 1'b0;
  logic       page_end = 1'b0;
  logic [1:0] err_code;
  logic       res_vld;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  m_main_dirty = 0;
  bit  m_tag_dirty  = 0;
  int  m_spare_idx  = 0;
  int  seed_dummy;

  always #5 clk = ~clk;

  ecc_blank_status dut_i (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_area(byte_area),
    .byte_val(byte_val), .ecc_any_err(ecc_any_err), .main_fail(main_fail),
    .tag_fail(tag_fail), .page_end(page_end), .err_code(err_code),
    .res_vld(res_vld)
  );

  task automatic check(input int act, input int exp, input string req);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_code(input bit any, input bit mf, input bit tf);
    if (!any) return 0;
    return ((mf && m_main_dirty) ? 2 : 0) + ((tf && m_tag_dirty) ? 1 : 0);
  endfunction

  function automatic void model_byte(input bit sp, input logic [7:0] v);
    if (!sp) begin
      if (v != 8'hFF) m_main_dirty = 1;
    end else begin
      if (m_spare_idx >= 4 && m_spare_idx < 24 && v != 8'hFF) m_tag_dirty = 1;
      m_spare_idx++;
    end
  endfunction

  task automatic put_byte(input bit sp, input logic [7:0] v);
    @(negedge clk);
    byte_vld = 1'b1; byte_area = sp; byte_val = v;
    model_byte(sp, v);
  endtask

  // strobe low with garbage on the byte lines (R11)
  task automatic idle_garbage();
    @(negedge clk);
    byte_vld = 1'b0; byte_area = 1'($urandom); byte_val = 8'h00;
  endtask

  task automatic close_page(input bit any, input bit mf, input bit tf,
                            input bit with_byte, input bit sp,
                            input logic [7:0] v, input string req);
    int e;
    @(negedge clk);
    page_end = 1'b1; ecc_any_err = any; main_fail = mf; tag_fail = tf;
    if (with_byte) begin
      byte_vld = 1'b1; byte_area = sp; byte_val = v; model_byte(sp, v);
    end else begin
      byte_vld = 1'b0;
    end
    e = exp_code(any, mf, tf);
    @(negedge clk);
    page_end = 1'b0; byte_vld = 1'b0;
    ecc_any_err = 1'($urandom); main_fail = 1'($urandom); tag_fail = 1'($urandom);
    check(res_vld, 1, {req, " R2 strobe"});
    check(err_code, e, req);
    m_main_dirty = 0; m_tag_dirty = 0; m_spare_idx = 0;
    @(negedge clk);
    check(res_vld, 0, "R2 single pulse");
    check(err_code, e, "R2 hold");
  endtask

  task automatic spare_run(input int n, input int bad_idx);
    for (int i = 0; i < n; i++) put_byte(1'b1, (i == bad_idx) ? 8'h5A : 8'hFF);
  endtask

  initial begin
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    check(err_code, 0, "R1 code in reset");
    check(res_vld, 0, "R1 strobe in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(err_code, 0, "R1 code after reset");
    check(res_vld, 0, "R1 strobe after reset");

    // R3: dirty everywhere, fails set, no global error
    put_byte(0, 8'h00); spare_run(24, 10);
    close_page(0, 1, 1, 0, 0, 8'h00, "R3");
    // R4: dirty main, blank tag
    put_byte(0, 8'hFF); put_byte(0, 8'h7F); spare_run(24, -1);
    close_page(1, 1, 1, 0, 0, 8'h00, "R4 dirty main");
    // R4: blank main with fail is masked
    for (int i = 0; i < 6; i++) put_byte(0, 8'hFF);
    close_page(1, 1, 0, 0, 0, 8'h00, "R4 blank main masked");
    // R5 window edges
    spare_run(24, 4);  close_page(1, 0, 1, 0, 0, 8'h00, "R5 idx4");
    spare_run(24, 23); close_page(1, 0, 1, 0, 0, 8'h00, "R5 idx23");
    // R6 outside window
    spare_run(30, 3);  close_page(1, 0, 1, 0, 0, 8'h00, "R6 idx3");
    spare_run(30, 24); close_page(1, 0, 1, 0, 0, 8'h00, "R6 idx24");
    // R7 spare-only read
    spare_run(24, 8);  close_page(1, 1, 1, 0, 0, 8'h00, "R7 spare only");
    // R8 dirty page then clean page
    put_byte(0, 8'h01); spare_run(24, 5);
    close_page(1, 1, 1, 0, 0, 8'h00, "R8 dirty page");
    put_byte(0, 8'hFF); spare_run(24, -1);
    close_page(1, 1, 1, 0, 0, 8'h00, "R8 clean after dirty");
    // R9 byte with page_end
    put_byte(0, 8'hFF);
    close_page(1, 1, 0, 1, 0, 8'h10, "R9 last byte counts");
    close_page(1, 1, 0, 0, 0, 8'h00, "R9 not carried over");
    // R10 both bits
    put_byte(0, 8'hAA); spare_run(24, 12);
    close_page(1, 1, 1, 0, 0, 8'h00, "R10 both");
    // R11 garbage while strobe low
    put_byte(0, 8'hFF); idle_garbage(); idle_garbage(); spare_run(24, -1);
    idle_garbage();
    close_page(1, 1, 1, 0, 0, 8'h00, "R11 ignored");

    // random pages
    for (int p = 0; p < 150; p++) begin
      int nm, ns;
      nm = ($urandom % 4 == 0) ? 0 : $urandom % 12;
      ns = $urandom % 40;
      for (int i = 0; i < nm; i++) begin
        put_byte(0, ($urandom % 10 == 0) ? 8'($urandom) : 8'hFF);
        if ($urandom % 6 == 0) idle_garbage();
      end
      for (int i = 0; i < ns; i++) begin
        put_byte(1, ($urandom % 20 == 0) ? 8'($urandom) : 8'hFF);
        if ($urandom % 6 == 0) idle_garbage();
      end
      close_page(($urandom % 4) != 0, 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), ($urandom % 2) ? 8'hFF : 8'h3C,
                 "R4 R5 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule